// File: doc/BRIEF.md
# Shift-Out Handshake Controller

This controller drives the read strobe of a strobe-handshake FIFO, the kind that has a shift-in strobe, a shift-out strobe, an output-ready flag and an input-ready flag. It runs on a system clock and samples the FIFO's flags each cycle. Whenever the FIFO shows a word and the downstream consumer is ready, it raises the shift-out strobe. At that same edge it captures the FIFO's output word into a holding register and pulses a valid flag for one clock.

The strobe follows the output-ready handshake. It stays high until the FIFO has pulled output-ready low, and only then does it drop. A strobe that lands in the FIFO's blind window is therefore stretched rather than lost. The controller also counts words in and out from the write strobe, the input-ready flag and its own completed reads. When a word is written into an empty FIFO, the first read is held back for a guard time of `GUARD_CYC` clocks after output-ready first rises. A selectable mode holds off all reading until the FIFO is more than half full, and then drains it completely.

Top module: `sohc_ctrl`

## Requirements
- R1: After reset, `fifo_so` is 0, `word_valid` is 0, `word_out` is 0, the word count is zero and the first-word guard is armed.
- R2: `fifo_so` rises only at a clock edge that samples both `fifo_or` and `cons_rdy` high.
- R3: Once `fifo_so` is high, it stays high while `fifo_or` is sampled high. It falls at the first edge that samples `fifo_or` low, so the high time equals the time until output-ready falls, plus one clock.
- R4: If a word enters an empty FIFO, `fifo_or` is first sampled high at edge e, and `cons_rdy` is held high, then `fifo_so` rises at edge e+GUARD_CYC+1.
- R5: If the FIFO is not empty when `fifo_or` rises again after a read, no guard applies and `fifo_so` rises at the first edge that samples `fifo_or` high.
- R6: The word count goes up on each rising `fifo_si` that is sampled while `fifo_ir` was high one clock earlier. It goes down on each falling `fifo_so`. The guard re-arms every time the count returns to zero.
- R7: `word_out` takes the value `fifo_do` has at the edge where `fifo_so` rises. It keeps that value until the next rise.
- R8: `word_valid` is high for exactly one clock, the first clock of each `fifo_so` high period.
- R9: With `half_mode` = 1, no read starts until the count exceeds DEPTH/2 (33 words for DEPTH = 64). Once started, reads continue until the count reaches zero.
- R10: With `half_mode` = 0, a single stored word is enough to start a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_mode | input | 1 | 1: start reading only above half full |
| cons_rdy | input | 1 | Downstream consumer can take a word |
| fifo_or | input | 1 | FIFO output-ready flag |
| fifo_ir | input | 1 | FIFO input-ready flag |
| fifo_si | input | 1 | FIFO shift-in strobe, observed |
| fifo_do | input | W | FIFO output data |
| fifo_so | output | 1 | Shift-out strobe to the FIFO |
| word_out | output | W | Captured output word |
| word_valid | output | 1 | One-clock flag for a new captured word |

## Verification
A behavioural FIFO in the bench answers the strobe with a programmable output-ready fall delay, so the strobe high time shows whether stretching follows the flag (R3) or a fixed pulse. Directed cases measure the gap from output-ready rise to strobe rise in three situations: a word written into an empty FIFO, a refill that never empties the FIFO, and the first word after a full drain. These gaps separate a working guard, a missing guard and a guard that never re-arms. A consumer held off, and a half-full run of 32 then 33 words, show the start gating. Random write pacing, random consumer readiness and random fall delays, with every captured word checked against a scoreboard, exercise ordering and capture timing.

// File: rtl/sohc_pkg.sv
package sohc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } rd_state_e;
endpackage

// File: rtl/sohc_fill_track.sv
// Occupancy, guard arming and half-full run gating, derived from the
// observed shift-in strobe, input-ready flag and completed reads.
module sohc_fill_track #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_si,
  input  logic fifo_ir,
  input  logic fifo_or,
  input  logic pop,
  output logic or_rise,
  output logic armed,
  output logic run
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic          si_q, ir_q, or_q;
  logic [CW-1:0] cnt, cnt_n;
  logic          armed_n, run_n;
  logic          wr;

  assign wr      = fifo_si & ~si_q & ir_q;
  assign or_rise = fifo_or & ~or_q;

  always_comb begin
    cnt_n = cnt;
    if (wr && !pop)      cnt_n = cnt + CW'(1);
    else if (!wr && pop) cnt_n = cnt - CW'(1);

    if (cnt_n == '0)  armed_n = 1'b1;
    else if (or_rise) armed_n = 1'b0;
    else              armed_n = armed;

    if (cnt_n == '0)             run_n = 1'b0;
    else if (cnt_n > CW'(HALF))  run_n = 1'b1;
    else                         run_n = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q  <= 1'b0;
      ir_q  <= 1'b0;
      or_q  <= 1'b0;
      cnt   <= '0;
      armed <= 1'b1;
      run   <= 1'b0;
    end else begin
      si_q  <= fifo_si;
      ir_q  <= fifo_ir;
      or_q  <= fifo_or;
      cnt   <= cnt_n;
      armed <= armed_n;
      run   <= run_n;
    end
  end
endmodule

// File: rtl/sohc_guard_timer.sv
// Counts the hold-off interval after output-ready rises on an empty FIFO.
module sohc_guard_timer #(
  parameter int GUARD_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int TW = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1);

  logic [TW-1:0] tmr, tmr_n;

  always_comb begin
    if (load)            tmr_n = TW'(GUARD_CYC);
    else if (tmr != '0)  tmr_n = tmr - TW'(1);
    else                 tmr_n = tmr;
  end

  assign busy = (tmr != '0) | (load & (GUARD_CYC != 0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= tmr_n;
  end
endmodule

// File: rtl/sohc_capture.sv
// Holding register loaded on the strobe's leading edge.
module sohc_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/sohc_ctrl.sv
module sohc_ctrl #(
  parameter int W         = 5,
  parameter int DEPTH     = 64,
  parameter int GUARD_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         half_mode,
  input  logic         cons_rdy,
  input  logic         fifo_or,
  input  logic         fifo_ir,
  input  logic         fifo_si,
  input  logic [W-1:0] fifo_do,
  output logic         fifo_so,
  output logic [W-1:0] word_out,
  output logic         word_valid
);
  import sohc_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rd_state_e st, st_n;
  logic      start, pop, or_rise, armed, run, guard_busy, gate_ok;

  sohc_fill_track #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_int_n), .fifo_si(fifo_si), .fifo_ir(fifo_ir),
    .fifo_or(fifo_or), .pop(pop), .or_rise(or_rise), .armed(armed), .run(run)
  );

  sohc_guard_timer #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_int_n), .load(armed & or_rise), .busy(guard_busy)
  );

  sohc_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .en(start), .d(fifo_do), .q(word_out)
  );

  assign gate_ok = ~half_mode | run;

  always_comb begin
    st_n  = st;
    start = 1'b0;
    pop   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (fifo_or && cons_rdy && !guard_busy && gate_ok) begin
          start = 1'b1;
          st_n  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!fifo_or) begin
          pop  = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st         <= ST_IDLE;
      word_valid <= 1'b0;
    end else begin
      st         <= st_n;
      word_valid <= start;
    end
  end

  assign fifo_so = (st == ST_HOLD);
endmodule

// File: rtl/sohc_chk.sv
module sohc_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cons_rdy,
  input logic         fifo_or,
  input logic [W-1:0] fifo_do,
  input logic         fifo_so,
  input logic [W-1:0] word_out,
  input logic         word_valid
);
  // R2
  so_rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_so) |-> ($past(fifo_or) && $past(cons_rdy)));
  // R3
  so_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_so && fifo_or) |=> fifo_so);
  // R3
  so_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_so) |-> !$past(fifo_or));
  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_so) |-> (word_out == $past(fifo_do)));
  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(fifo_so) |-> $stable(word_out));
  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R8
  valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (fifo_so && !$past(fifo_so)));
endmodule

bind sohc_ctrl sohc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cons_rdy(cons_rdy), .fifo_or(fifo_or),
  .fifo_do(fifo_do), .fifo_so(fifo_so), .word_out(word_out),
  .word_valid(word_valid)
);

// File: tb/sohc_ctrl_tb.sv
module sohc_ctrl_tb;
  localparam int W = 5;
  localparam int DEPTH = 64;
  localparam int G = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_mode = 1'b0;
  logic cons_rdy = 1'b0;
  logic or_r = 1'b0, ir_r = 1'b1, si_r = 1'b0;
  logic [W-1:0] do_r = '0;
  logic fifo_so, word_valid;
  logic [W-1:0] word_out;

  always #2 clk = ~clk;

  sohc_ctrl #(.W(W), .DEPTH(DEPTH), .GUARD_CYC(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .cons_rdy(cons_rdy),
    .fifo_or(or_r), .fifo_ir(ir_r), .fifo_si(si_r), .fifo_do(do_r),
    .fifo_so(fifo_so), .word_out(word_out), .word_valid(word_valid)
  );

  int checks = 0, failures = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  function automatic int guard_gap(bit from_empty);
    return from_empty ? G + 2 : 1;
  endfunction

  // behavioural FIFO and scoreboard, all on the falling edge
  logic [W-1:0] q[$];
  logic [W-1:0] exp_q[$];
  int cyc = 0, back_dly = 0, fall_wait = 0, stretch = 0, stretch_used = 0;
  bit fall_active = 0, so_prev = 0, valid_prev = 0, wr_pend = 0;
  logic [W-1:0] wr_data;
  int or_stamp = 0, so_stamp = 0, gap_last = 0, hi_len = 0, rd_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (word_valid) begin
      chk(exp_q.size() > 0, "R7 scoreboard size", exp_q.size(), 1);
      if (exp_q.size() > 0) begin
        chk(word_out == exp_q[0], "R7 captured word", word_out, exp_q[0]);
        void'(exp_q.pop_front());
      end
      chk(fifo_so && !so_prev, "R8 valid on strobe rise", fifo_so, 1);
      rd_cnt++;
    end
    if (valid_prev) chk(!word_valid, "R8 valid one clock", word_valid, 0);
    valid_prev = word_valid;
    if (fifo_so) hi_len++;
    if (fifo_so && !so_prev) begin
      so_stamp = cyc;
      gap_last = so_stamp - or_stamp;
      hi_len = 1;
      stretch_used = stretch;
      fall_wait = stretch;
      fall_active = 1;
    end
    if (fall_active) begin
      if (fall_wait == 0) begin or_r = 1'b0; fall_active = 0; end
      else fall_wait--;
    end
    if (!fifo_so && so_prev) begin
      chk(hi_len == stretch_used + 1, "R3 strobe high time", hi_len, stretch_used + 1);
      if (q.size() > 0) void'(q.pop_front());
      back_dly = 2;
    end
    if (si_r) si_r = 1'b0;
    else if (wr_pend && ir_r) begin
      si_r = 1'b1;
      if (q.size() == 0) back_dly = 2;
      q.push_back(wr_data);
      exp_q.push_back(wr_data);
      wr_pend = 0;
    end
    if (!or_r && !fifo_so && !fall_active && q.size() > 0) begin
      if (back_dly > 0) back_dly--;
      else begin or_r = 1'b1; do_r = q[0]; or_stamp = cyc; end
    end
    ir_r = (q.size() < DEPTH);
    so_prev = fifo_so;
  end

  task automatic put(input logic [W-1:0] d);
    @(posedge clk); #1;
    wr_data = d;
    wr_pend = 1;
    while (wr_pend) @(posedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    // R1 reset state
    chk(fifo_so == 0, "R1 strobe low", fifo_so, 0);
    chk(word_valid == 0, "R1 valid low", word_valid, 0);
    chk(word_out == 0, "R1 word zero", word_out, 0);
    rst_n = 1'b1;
    idle(4);

    // R2 consumer not ready: no read
    base = rd_cnt;
    put(5'h11);
    idle(12);
    chk(rd_cnt == base, "R2 held while not ready", rd_cnt, base);
    chk(fifo_so == 0, "R2 strobe low", fifo_so, 0);
    cons_rdy = 1'b1;
    idle(10);
    chk(rd_cnt == base + 1, "R2 read after ready", rd_cnt, base + 1);

    // R1 R4 first word into empty FIFO is guarded; R10 one word suffices
    put(5'h0a);
    idle(12);
    chk(gap_last == guard_gap(1), "R4 guard gap", gap_last, guard_gap(1));
    chk(rd_cnt == base + 2, "R10 single word read", rd_cnt, base + 2);

    // R5 refill without draining: no guard; R3 stretched strobe
    cons_rdy = 1'b0;
    stretch = 4;
    put(5'h01); put(5'h02); put(5'h03);
    idle(6);
    cons_rdy = 1'b1;
    idle(8);
    idle(20);
    chk(gap_last == guard_gap(0), "R5 no guard when nonempty", gap_last, guard_gap(0));
    chk(exp_q.size() == 0, "R5 drained", exp_q.size(), 0);

    // R6 re-armed after drain
    stretch = 0;
    put(5'h1f);
    idle(12);
    chk(gap_last == guard_gap(1), "R6 guard re-armed", gap_last, guard_gap(1));

    // R9 half mode
    half_mode = 1'b1;
    base = rd_cnt;
    for (int i = 0; i < DEPTH / 2; i++) put(W'(i));
    idle(20);
    chk(rd_cnt == base, "R9 no read at half", rd_cnt, base);
    put(5'h15);
    idle(400);
    chk(rd_cnt == base + DEPTH / 2 + 1, "R9 full drain", rd_cnt, base + DEPTH / 2 + 1);
    chk(exp_q.size() == 0, "R9 empty after run", exp_q.size(), 0);
    half_mode = 1'b0;

    // R6 R7 random traffic against the scoreboard
    void'($urandom(32'h5eed));
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          put(W'($urandom));
          idle($urandom % 4);
        end
      end
      begin
        for (int i = 0; i < 1500; i++) begin
          @(posedge clk); #1;
          cons_rdy = ($urandom % 4) != 0;
          stretch = $urandom % 3;
        end
      end
    join
    cons_rdy = 1'b1;
    stretch = 0;
    idle(400);
    chk(exp_q.size() == 0, "R6 random drained", exp_q.size(), 0);
    chk(fifo_so == 0, "R3 strobe idle at end", fifo_so, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule